// File: doc/BRIEF.md
# Serial Configuration Register Decoder

This block sits on the receiving end of a four-wire serial configuration bus on a front-end board. Every transfer is a 32-bit word that carries a select code, a command nibble, a register index and a 16-bit payload. The block decodes each completed word and reads or writes one of four register groups:

- sixteen 16-bit PWM settings;
- a read-only group holding the board's unique ID and temperature;
- an I/O control group with an input-disable mask, LED control and a test-pin selector;
- a small byte-wide scratch RAM.

The serial pins are oversampled on the system clock. A word takes effect only when chip select rises after exactly 32 bits. A read command captures the addressed value, and that value is shifted out on MISO during the following transfer. The PWM settings, disable mask, LED drive and test-pin selection leave the block as plain outputs for the logic around it.

Top module: `fe_cfg_spi_slave`

## Requirements
- R1: A word is sent MSB first and sampled on rising SCLK edges while CS_n is low (SPI mode 0). Its fields are: select code in bits 31..24, command in 23..20, register index in 19..16, payload in 15..0.
- R2: A word is acted upon only when CS_n rises after exactly 32 SCLK rising edges. A shorter or longer frame changes no register and leaves the captured read value unchanged.
- R3: Command 8 writes and command 0 reads. Any other command value changes no register and no read value.
- R4: Select 0x00 reads and writes PWM setting n (n = index 0..15), which drives bits [16n+15:16n] of the PWM output bus.
- R5: Select 0x10 is read-only. Index k = 0..3 returns unique ID bits [16k+15:16k], index 4 returns the temperature, and any other index returns 0. Writes to this group have no effect.
- R6: Select 0x20 index 0 is the input-disable mask, one bit per input (1 = disabled). It reads back as written and resets to all zeros, so every input is enabled after reset.
- R7: Select 0x20 index 1 reads the live pin status. Writes to it have no effect.
- R8: Select 0x20 index 2: a write stores payload bits 3..0 as the LED value and bit 4 as the override enable. With override set, the LED outputs show the stored value. With override clear, they follow the activity inputs. A read returns {override, LED outputs} in bits 4..0.
- R9: Select 0x20 index 3 holds a 4-bit input index taken from payload bits 3..0. The test output carries the pin-status bit at that index, and the register reads back as written.
- R10: Select 0x40 reads and writes a 16 x 8-bit RAM. A write stores payload bits 7..0, and a read returns the byte in bits 7..0 with zeros above.
- R11: The most recent captured read value appears in bits 15..0 of the next frame's MISO data, MSB first, with bits 31..16 zero. It is held until the next valid read. Reads of unmapped select codes or unused indices return 0, and writes to them have no effect.
- R12: After reset, all PWM settings, the mask, the LED override, the test index and the captured read value are zero. MISO is low while CS_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spiSclk | input | 1 | Serial clock |
| spiCsN | input | 1 | Active-low chip select, framing one word |
| spiMosi | input | 1 | Serial data into the block |
| spiMiso | output | 1 | Serial read data out of the block |
| uniqueId | input | 64 | Board unique ID |
| temperature | input | 16 | Temperature reading |
| pinStatus | input | 16 | Live state of the inputs |
| activity | input | 4 | Internal activity indicators for the LEDs |
| pwmSettings | output | 256 | Sixteen 16-bit PWM settings, channel 0 in the low bits |
| inputDisable | output | 16 | Per-input disable mask |
| ledOut | output | 4 | LED drive |
| testSel | output | 4 | Input index routed to the test output |
| testOut | output | 1 | Selected pin-status bit |

## Verification
Faults in the write path or index decode show up in the output cycle right after the frame is committed. Each such fault changes one PWM word, mask bit, LED value or test selection, within about a dozen clocks of CS_n rising. Errors in the read path, such as a wrong group multiplexer, a stale or overwritten captured value, or a bad shift order, appear only one frame later, as wrong bits on MISO. Framing faults appear as a register that changes after a 31- or 33-bit frame. A lost or duplicated bit count shows as every following frame being ignored or misdecoded.

// File: rtl/fe_cfg_pkg.sv
package fe_cfg_pkg;
  localparam int WORD_W = 32;
  localparam int DATA_W = 16;

  localparam logic [3:0] CMD_READ  = 4'h0;
  localparam logic [3:0] CMD_WRITE = 4'h8;

  localparam logic [7:0] SEL_PWM = 8'h00;
  localparam logic [7:0] SEL_ID  = 8'h10;
  localparam logic [7:0] SEL_IO  = 8'h20;
  localparam logic [7:0] SEL_RAM = 8'h40;

  typedef struct packed {
    logic              wrEn;
    logic              rdEn;
    logic [7:0]        sel;
    logic [3:0]        chan;
    logic [DATA_W-1:0] data;
  } cfg_strobe_t;
endpackage

// File: rtl/fe_cfg_spi_ctrl.sv
module fe_cfg_spi_ctrl
  import fe_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spiSclk,
  input  logic              spiCsN,
  input  logic              spiMosi,
  output logic              spiMiso,
  input  logic [DATA_W-1:0] readData,
  output cfg_strobe_t       stb
);
  localparam int CNT_MAX = WORD_W + 1;
  localparam int CNT_W   = $clog2(WORD_W + 2);

  logic [2:0] sclkQ, csQ;
  logic [1:0] mosiQ;
  logic [WORD_W-1:0] rxShift, txShift;
  logic [CNT_W-1:0]  bitCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclkQ <= '0;
      csQ   <= '1;
      mosiQ <= '0;
    end else begin
      sclkQ <= {sclkQ[1:0], spiSclk};
      csQ   <= {csQ[1:0], spiCsN};
      mosiQ <= {mosiQ[0], spiMosi};
    end
  end

  logic active, sclkRise, sclkFall, csFall, csRise;
  assign active   = ~csQ[1];
  assign sclkRise =  sclkQ[1] & ~sclkQ[2];
  assign sclkFall = ~sclkQ[1] &  sclkQ[2];
  assign csFall   = ~csQ[1] &  csQ[2];
  assign csRise   =  csQ[1] & ~csQ[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxShift <= '0;
      txShift <= '0;
      bitCnt  <= '0;
    end else if (csFall) begin
      bitCnt  <= '0;
      txShift <= {{(WORD_W-DATA_W){1'b0}}, readData};
    end else if (active) begin
      if (sclkRise) begin
        rxShift <= {rxShift[WORD_W-2:0], mosiQ[1]};
        if (bitCnt != CNT_W'(CNT_MAX)) bitCnt <= bitCnt + 1'b1;
      end
      if (sclkFall) txShift <= {txShift[WORD_W-2:0], 1'b0};
    end
  end

  assign spiMiso = active & txShift[WORD_W-1];

  logic frameOk;
  assign frameOk = csRise && (bitCnt == CNT_W'(WORD_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb <= '0;
    end else begin
      stb.wrEn <= frameOk && (rxShift[23:20] == CMD_WRITE);
      stb.rdEn <= frameOk && (rxShift[23:20] == CMD_READ);
      if (frameOk) begin
        stb.sel  <= rxShift[31:24];
        stb.chan <= rxShift[19:16];
        stb.data <= rxShift[15:0];
      end
    end
  end

  // R2: a strobe only follows a chip-select rise that closed a 32-bit frame
  a_r2_strobe_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wrEn || stb.rdEn) |-> ($past(csRise) && $past(bitCnt) == CNT_W'(WORD_W)));
  // R1: bit counting restarts at the start of every frame
  a_r1_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    csFall |=> (bitCnt == '0));
  // R3: read and write never issue together
  a_r3_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({stb.wrEn, stb.rdEn}) <= 1);
endmodule

// File: rtl/fe_cfg_regs.sv
module fe_cfg_regs
  import fe_cfg_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int PWM_W     = 16,
  parameter int NUM_IN    = 16,
  parameter int NUM_LED   = 4,
  parameter int RAM_DEPTH = 16,
  parameter int RAM_W     = 8,
  parameter int ID_WORDS  = 4
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  cfg_strobe_t             stb,
  input  logic [ID_WORDS*DATA_W-1:0] uniqueId,
  input  logic [DATA_W-1:0]       temperature,
  input  logic [NUM_IN-1:0]       pinStatus,
  input  logic [NUM_LED-1:0]      activity,
  output logic [DATA_W-1:0]       readData,
  output logic [NUM_CH*PWM_W-1:0] pwmSettings,
  output logic [NUM_IN-1:0]       inputDisable,
  output logic [NUM_LED-1:0]      ledOut,
  output logic [3:0]              testSel,
  output logic                    testOut
);
  localparam int CH_AW  = $clog2(NUM_CH);
  localparam int RAM_AW = $clog2(RAM_DEPTH);
  localparam int IN_AW  = $clog2(NUM_IN);

  logic [PWM_W-1:0]   pwmReg [NUM_CH];
  logic [RAM_W-1:0]   ramReg [RAM_DEPTH];
  logic [NUM_IN-1:0]  disReg;
  logic [NUM_LED-1:0] ledVal;
  logic               ledOv;
  logic [3:0]         tSel;
  logic [DATA_W-1:0]  rdVal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) pwmReg[i] <= '0;
    end else if (stb.wrEn && stb.sel == SEL_PWM && 32'(stb.chan) < NUM_CH) begin
      pwmReg[stb.chan[CH_AW-1:0]] <= stb.data[PWM_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RAM_DEPTH; i++) ramReg[i] <= '0;
    end else if (stb.wrEn && stb.sel == SEL_RAM && 32'(stb.chan) < RAM_DEPTH) begin
      ramReg[stb.chan[RAM_AW-1:0]] <= stb.data[RAM_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disReg <= '0;
      ledVal <= '0;
      ledOv  <= 1'b0;
      tSel   <= '0;
    end else if (stb.wrEn && stb.sel == SEL_IO) begin
      case (stb.chan)
        4'd0: disReg <= stb.data[NUM_IN-1:0];
        4'd2: begin
          ledVal <= stb.data[NUM_LED-1:0];
          ledOv  <= stb.data[4];
        end
        4'd3: tSel <= stb.data[3:0];
        default: ;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_pwm
      assign pwmSettings[g*PWM_W +: PWM_W] = pwmReg[g];
    end
  endgenerate

  assign inputDisable = disReg;
  assign ledOut       = ledOv ? ledVal : activity;
  assign testSel      = tSel;
  assign testOut      = pinStatus[tSel[IN_AW-1:0]];

  always_comb begin
    rdVal = '0;
    case (stb.sel)
      SEL_PWM: if (32'(stb.chan) < NUM_CH) rdVal = DATA_W'(pwmReg[stb.chan[CH_AW-1:0]]);
      SEL_ID: begin
        if (32'(stb.chan) < ID_WORDS) rdVal = uniqueId[stb.chan*DATA_W +: DATA_W];
        else if (32'(stb.chan) == ID_WORDS) rdVal = temperature;
      end
      SEL_IO: begin
        case (stb.chan)
          4'd0: rdVal = DATA_W'(disReg);
          4'd1: rdVal = DATA_W'(pinStatus);
          4'd2: rdVal = DATA_W'({ledOv, ledOut});
          4'd3: rdVal = DATA_W'(tSel);
          default: rdVal = '0;
        endcase
      end
      SEL_RAM: if (32'(stb.chan) < RAM_DEPTH) rdVal = DATA_W'(ramReg[stb.chan[RAM_AW-1:0]]);
      default: rdVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) readData <= '0;
    else if (stb.rdEn) readData <= rdVal;
  end

  // R11: the captured read value only moves on a read strobe
  a_r11_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.rdEn |=> $stable(readData));
  // R11: unmapped select codes read back zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rdEn && stb.sel != SEL_PWM && stb.sel != SEL_ID && stb.sel != SEL_IO &&
     stb.sel != SEL_RAM) |=> (readData == '0));
  // R4: a PWM write lands in the addressed channel on the next cycle
  a_r4_pwm_write: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wrEn && stb.sel == SEL_PWM) |=>
      (pwmSettings[$past(stb.chan[CH_AW-1:0])*PWM_W +: PWM_W] == $past(stb.data[PWM_W-1:0])));
  // R5: writes to the read-only group leave every PWM setting untouched
  a_r5_ro_group: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wrEn && stb.sel == SEL_ID) |=> $stable(pwmSettings));
endmodule

// File: rtl/fe_cfg_spi_slave.sv
module fe_cfg_spi_slave
  import fe_cfg_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int PWM_W   = 16,
  parameter int NUM_IN  = 16,
  parameter int NUM_LED = 4
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spiSclk,
  input  logic                    spiCsN,
  input  logic                    spiMosi,
  output logic                    spiMiso,
  input  logic [63:0]             uniqueId,
  input  logic [15:0]             temperature,
  input  logic [NUM_IN-1:0]       pinStatus,
  input  logic [NUM_LED-1:0]      activity,
  output logic [NUM_CH*PWM_W-1:0] pwmSettings,
  output logic [NUM_IN-1:0]       inputDisable,
  output logic [NUM_LED-1:0]      ledOut,
  output logic [3:0]              testSel,
  output logic                    testOut
);
  cfg_strobe_t       stb;
  logic [DATA_W-1:0] readData;

  fe_cfg_spi_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .spiSclk  (spiSclk),
    .spiCsN   (spiCsN),
    .spiMosi  (spiMosi),
    .spiMiso  (spiMiso),
    .readData (readData),
    .stb      (stb)
  );

  fe_cfg_regs #(
    .NUM_CH  (NUM_CH),
    .PWM_W   (PWM_W),
    .NUM_IN  (NUM_IN),
    .NUM_LED (NUM_LED)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .stb          (stb),
    .uniqueId     (uniqueId),
    .temperature  (temperature),
    .pinStatus    (pinStatus),
    .activity     (activity),
    .readData     (readData),
    .pwmSettings  (pwmSettings),
    .inputDisable (inputDisable),
    .ledOut       (ledOut),
    .testSel      (testSel),
    .testOut      (testOut)
  );
endmodule

// File: tb/fe_cfg_spi_slave_tb.sv
module fe_cfg_spi_slave_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, spiSclk, spiCsN, spiMosi, spiMiso;
  logic [63:0]  uniqueId;
  logic [15:0]  temperature, pinStatus;
  logic [3:0]   activity;
  logic [255:0] pwmSettings;
  logic [15:0]  inputDisable;
  logic [3:0]   ledOut, testSel;
  logic         testOut;

  fe_cfg_spi_slave u_dut (
    .clk(clk), .rst_n(rst_n), .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .uniqueId(uniqueId), .temperature(temperature),
    .pinStatus(pinStatus), .activity(activity), .pwmSettings(pwmSettings),
    .inputDisable(inputDisable), .ledOut(ledOut), .testSel(testSel), .testOut(testOut)
  );

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  logic [15:0] mPwm [16];
  logic [7:0]  mRam [16];
  logic [15:0] mDis;
  logic [3:0]  mLed, mTsel;
  logic        mOv;
  logic [15:0] mLast;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] expLed();
    return mOv ? mLed : activity;
  endfunction

  function automatic logic [15:0] expRead(input logic [7:0] sel, input logic [3:0] ch);
    case (sel)
      8'h00: return mPwm[ch];
      8'h10: return (ch < 4) ? uniqueId[ch*16 +: 16] : ((ch == 4) ? temperature : 16'h0);
      8'h20: case (ch)
               4'd0: return mDis;
               4'd1: return pinStatus;
               4'd2: return {11'h0, mOv, expLed()};
               4'd3: return {12'h0, mTsel};
               default: return 16'h0;
             endcase
      8'h40: return {8'h0, mRam[ch]};
      default: return 16'h0;
    endcase
  endfunction

  task automatic applyModel(input logic [31:0] w);
    logic [7:0] sel = w[31:24];
    logic [3:0] cmd = w[23:20];
    logic [3:0] ch  = w[19:16];
    if (cmd == 4'h0) mLast = expRead(sel, ch);
    else if (cmd == 4'h8) begin
      case (sel)
        8'h00: mPwm[ch] = w[15:0];
        8'h40: mRam[ch] = w[7:0];
        8'h20: case (ch)
                 4'd0: mDis = w[15:0];
                 4'd2: begin mLed = w[3:0]; mOv = w[4]; end
                 4'd3: mTsel = w[3:0];
                 default: ;
               endcase
        default: ;
      endcase
    end
  endtask

  task automatic spiXfer(input logic [31:0] w, input int nbits, output logic [31:0] rx);
    rx = '0;
    spiCsN = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spiMosi = (i < 32) ? w[31-i] : 1'b0;
      repeat (6) @(negedge clk);
      rx = {rx[30:0], spiMiso};
      spiSclk = 1'b1;
      repeat (8) @(negedge clk);
      spiSclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    spiCsN = 1'b1;
    spiMosi = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  // one frame: checks the returned bits, updates the model, checks outputs
  task automatic frame(input logic [31:0] w, input int nbits, input string tag);
    logic [31:0] rx;
    logic [31:0] expRx = {16'h0, mLast};
    spiXfer(w, nbits, rx);
    if (nbits == 32) begin
      chk({tag, " R11 readback"}, 64'(rx), 64'(expRx));
      applyModel(w);
    end
    checkOutputs(tag);
  endtask

  task automatic checkOutputs(input string tag);
    for (int c = 0; c < 16; c++) chk({tag, " R4 pwm"}, 64'(pwmSettings[c*16 +: 16]), 64'(mPwm[c]));
    chk({tag, " R6 mask"}, 64'(inputDisable), 64'(mDis));
    chk({tag, " R8 led"}, 64'(ledOut), 64'(expLed()));
    chk({tag, " R9 testSel"}, 64'(testSel), 64'(mTsel));
    chk({tag, " R9 testOut"}, 64'(testOut), 64'(pinStatus[mTsel]));
  endtask

  function automatic logic [31:0] mk(input logic [7:0] s, input logic [3:0] c,
                                     input logic [3:0] ch, input logic [15:0] d);
    return {s, c, ch, d};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0; spiSclk = 1'b0; spiCsN = 1'b1; spiMosi = 1'b0;
    uniqueId = 64'h0123_4567_89AB_CDEF; temperature = 16'h0A5C;
    pinStatus = 16'hA55A; activity = 4'h6;
    for (int i = 0; i < 16; i++) begin mPwm[i] = '0; mRam[i] = '0; end
    mDis = '0; mLed = '0; mTsel = '0; mOv = 1'b0; mLast = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12 reset state, R6 default mask, R8 LEDs follow activity
    chk("R12 pwm reset", 64'(pwmSettings == '0), 64'd1);
    chk("R12 miso idle", 64'(spiMiso), 64'd0);
    checkOutputs("R12 reset");

    // R1 R4 directed write, then read, then value returned in the next frame
    frame(mk(8'h00, 4'h8, 4'd5, 16'hBEEF), 32, "R1 pwm wr");
    frame(mk(8'h00, 4'h0, 4'd5, 16'h0000), 32, "R4 pwm rd");
    frame(mk(8'h99, 4'h3, 4'd0, 16'h0000), 32, "R3 nop");
    // R2 short and long frames are dropped
    frame(mk(8'h00, 4'h8, 4'd5, 16'h1111), 31, "R2 short");
    frame(mk(8'h00, 4'h8, 4'd5, 16'h2222), 33, "R2 long");
    frame(mk(8'h00, 4'h0, 4'd7, 16'h0000), 31, "R2 short rd");
    frame(mk(8'h77, 4'h3, 4'd0, 16'h0000), 32, "R2 latch kept");
    // R5 read-only group: write ignored, ID words and temperature readable
    frame(mk(8'h10, 4'h8, 4'd0, 16'hFFFF), 32, "R5 ro wr");
    frame(mk(8'h10, 4'h0, 4'd3, 16'h0000), 32, "R5 id3");
    frame(mk(8'h10, 4'h0, 4'd4, 16'h0000), 32, "R5 temp");
    frame(mk(8'h20, 4'h0, 4'd1, 16'h0000), 32, "R7 pins");
    // R8 override on, then off
    frame(mk(8'h20, 4'h8, 4'd2, 16'h001A), 32, "R8 ovr on");
    frame(mk(8'h20, 4'h0, 4'd2, 16'h0000), 32, "R8 ovr rd");
    frame(mk(8'h20, 4'h8, 4'd2, 16'h0003), 32, "R8 ovr off");
    // R9 test index, R10 RAM, R11 unmapped select
    frame(mk(8'h20, 4'h8, 4'd3, 16'hFFF9), 32, "R9 tsel");
    frame(mk(8'h40, 4'h8, 4'd15, 16'hABCD), 32, "R10 ram wr");
    frame(mk(8'h40, 4'h0, 4'd15, 16'h0000), 32, "R10 ram rd");
    frame(mk(8'h33, 4'h8, 4'd0, 16'h1234), 32, "R11 unmapped wr");
    frame(mk(8'h33, 4'h0, 4'd0, 16'h0000), 32, "R11 unmapped rd");
    frame(mk(8'h00, 4'h3, 4'd0, 16'h0000), 32, "R11 flush");

    for (int n = 0; n < 170; n++) begin
      logic [7:0] sel;
      logic [3:0] cmd;
      int nb;
      int pick = int'($urandom_range(0, 9));
      sel = (pick < 3) ? 8'h00 : (pick < 5) ? 8'h20 : (pick < 7) ? 8'h40 :
            (pick < 9) ? 8'h10 : 8'($urandom);
      pick = int'($urandom_range(0, 9));
      cmd = (pick < 4) ? 4'h0 : (pick < 8) ? 4'h8 : 4'($urandom);
      nb = ($urandom_range(0, 9) == 0) ? int'($urandom_range(1, 40)) : 32;
      if ($urandom_range(0, 4) == 0) begin
        pinStatus = 16'($urandom);
        activity  = 4'($urandom);
        repeat (2) @(negedge clk);
      end
      frame(mk(sel, cmd, 4'($urandom), 16'($urandom)), nb, "R1 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule